// File: doc/BRIEF.md
# Slave Serial Audio Data Transmitter

This block sends a stereo pair of 16-bit PCM words per frame out of one serial data pin. It works as a clock follower: the bit clock and the word (frame) clock come in from outside and are oversampled by a faster core clock. The block finds their edges, counts bit slots inside each half-frame, and puts one data bit on the output after every falling edge of the bit clock. A static format input selects between two MSB-first alignments. In left-justified alignment the MSB sits in the first slot of a half-frame and the left word is sent while the frame clock is high. In I2S alignment the MSB is one slot later and the left word is sent while the frame clock is low.

Sample pairs arrive on a valid/ready stream into a one-entry holding register. The transmitter empties that register at the start of every left half-frame, so the left and right words of one frame always belong to the same sample instant. `smp_ready_o` is high only while the holding register is empty. A producer that offers a pair while ready is low must keep `smp_valid_i` and the data steady until ready returns; the block never drops or overwrites a held pair. If no pair is held when a left half-frame starts, the frame is sent as zeros. A mute input forces zero on every bit it covers. Frame lengths of 64, 48 or 32 bit clocks per frame-clock period need no configuration, because the slot counter restarts on every frame-clock transition.

Top module: `serial_audio_tx`

## Requirements
- R1: After reset `sdata_o` is 0 and `smp_ready_o` is 1, and the output stays 0 until the first frame-clock transition.
- R2: With `fmt_i`=0 (left-justified), the word's bit 15 is sent in slot 0 of the half-frame, which is the bit period launched by the falling bit-clock edge that carries the frame-clock transition. Lower bits follow MSB first, so bit 0 is in slot 15.
- R3: With `fmt_i`=1 (I2S), slot 0 of every half-frame is 0, bit 15 is sent in slot 1 and bit 0 in slot 16.
- R4: The left word goes out in the half-frame where `lrclk_i` equals NOT `fmt_i`, so frame clock high for left-justified and low for I2S. The right word goes out in the other half-frame.
- R5: Every slot after the LSB, up to the end of the half-frame, is 0.
- R6: Frames of 64, 48 and 32 bit clocks work in left-justified mode, and frames of 64 and 48 work in I2S mode, with no configuration change.
- R7: A pair accepted while `smp_valid_i` and `smp_ready_o` are both high is held unchanged, with ready low, until the next left half-frame starts. It is then sent as that frame's left and right words.
- R8: If no pair is held at the start of a left half-frame, both words of that frame are sent as 0.
- R9: While `mute_i` is high at a bit-clock falling edge, the bit launched by that edge is 0.
- R10: `sdata_o` changes only in response to a bit-clock falling edge, and is stable across the following high phase of the bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bit and frame clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock from the external clock master |
| lrclk_i | input | 1 | Frame clock that selects the channel, from the external clock master |
| fmt_i | input | 1 | Alignment select: 0 left-justified, 1 I2S |
| mute_i | input | 1 | Forces zero data while high |
| smp_valid_i | input | 1 | Producer has a sample pair on the data inputs |
| smp_ready_o | output | 1 | Holding register is empty and can take a pair |
| smp_left_i | input | 16 | Left channel word, two's complement |
| smp_right_i | input | 16 | Right channel word, two's complement |
| sdata_o | output | 1 | Serial audio data output |

## Verification
The bench targets three kinds of slip. The first is the one-slot offset between the two alignments: a design that applied the wrong lead would shift every word by one bit and double or halve its value. The second is the channel phase: if it were inverted, the left and right words would arrive in each other's half-frames. The third is the boundary at the end of a short half-frame: with 32-clock frames the LSB sits in the last slot, and with longer frames a design that failed to pad would repeat stale bits. The bench also covers a pair offered while the holding register is full, an empty holding register at a frame start, and mute. A design that overwrote the held pair, replayed the old pair, or let mute through would all put visibly wrong bits on the data pin.

// File: rtl/sdtx_pkg.sv
package sdtx_pkg;

  typedef enum logic {
    FMT_LEFT_JUST = 1'b0,
    FMT_I2S       = 1'b1
  } sdtx_fmt_e;

  // Number of idle slots before the MSB of a half-frame
  function automatic logic lead_slots(input sdtx_fmt_e f);
    return (f == FMT_I2S);
  endfunction

endpackage

// File: rtl/sdtx_edge.sv
module sdtx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic lrclk_i,
  output logic bit_fall_o,
  output logic lr_held_o
);

  logic bclk_q;

  // Reset to high so a bit clock parked high is not taken as an edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q    <= 1'b1;
      lr_held_o <= 1'b0;
    end else begin
      bclk_q <= bclk_i;
      if (bclk_i && !bclk_q) lr_held_o <= lrclk_i;
    end
  end

  assign bit_fall_o = bclk_q && !bclk_i;

endmodule

// File: rtl/sdtx_hold.sv
module sdtx_hold #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o
);

  assign ready_o = !full_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_o  <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
    end else if (valid_i && ready_o) begin
      full_o  <= 1'b1;
      left_o  <= left_i;
      right_o <= right_i;
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o) |=> !ready_o); // R7

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !take_i) |=> ($stable(left_o) && $stable(right_o) && full_o)); // R7

endmodule

// File: rtl/sdtx_shift.sv
module sdtx_shift
  import sdtx_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_fall_i,
  input  logic              lrclk_i,
  input  logic              lr_held_i,
  input  sdtx_fmt_e         fmt_i,
  input  logic              mute_i,
  input  logic              hold_full_i,
  input  logic [WORD_W-1:0] hold_left_i,
  input  logic [WORD_W-1:0] hold_right_i,
  output logic              take_o,
  output logic              sdata_o
);

  localparam int unsigned  IDX_W    = $clog2(WORD_W);
  localparam logic [SLOT_W-1:0] SLOT_TOP = {SLOT_W{1'b1}};
  localparam logic [SLOT_W-1:0] SLOT_WORD = SLOT_W'(WORD_W);

  logic [SLOT_W-1:0] slot_q, slot_nxt, dly, idx;
  logic [WORD_W-1:0] left_q, right_q, left_nxt, right_nxt, word;
  logic [IDX_W-1:0]  bit_sel;
  logic              new_half, left_phase, left_start, in_range, bit_nxt;

  assign new_half   = bit_fall_i && (lrclk_i != lr_held_i);
  assign left_phase = lrclk_i ^ fmt_i;
  assign left_start = new_half && left_phase;
  assign take_o     = left_start && hold_full_i;

  always_comb begin
    if (new_half)               slot_nxt = '0;
    else if (slot_q == SLOT_TOP) slot_nxt = slot_q;
    else                        slot_nxt = slot_q + 1'b1;
  end

  always_comb begin
    left_nxt  = left_q;
    right_nxt = right_q;
    if (left_start) begin
      left_nxt  = hold_full_i ? hold_left_i  : '0;
      right_nxt = hold_full_i ? hold_right_i : '0;
    end
  end

  assign word     = left_phase ? left_nxt : right_nxt;
  assign dly      = {{(SLOT_W-1){1'b0}}, lead_slots(fmt_i)};
  assign idx      = slot_nxt - dly;
  assign in_range = (slot_nxt >= dly) && (idx < SLOT_WORD);
  assign bit_sel  = IDX_W'(WORD_W - 1) - idx[IDX_W-1:0];
  assign bit_nxt  = in_range && !mute_i && word[bit_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q  <= SLOT_TOP;
      left_q  <= '0;
      right_q <= '0;
      sdata_o <= 1'b0;
    end else if (bit_fall_i) begin
      slot_q  <= slot_nxt;
      left_q  <= left_nxt;
      right_q <= right_nxt;
      sdata_o <= bit_nxt;
    end
  end

  AST_I2S_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (new_half && fmt_i == FMT_I2S) |=> !sdata_o); // R3

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_fall_i && !new_half && slot_q >= SLOT_WORD) |=> !sdata_o); // R5

  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_fall_i && mute_i) |=> !sdata_o); // R9

  AST_EMPTY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (left_start && !hold_full_i) |=> (left_q == '0 && right_q == '0)); // R8

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import sdtx_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned MAX_FRAME = 64,
  localparam int unsigned SLOT_W   = $clog2(MAX_FRAME)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  logic              fmt_i,
  input  logic              mute_i,
  input  logic              smp_valid_i,
  output logic              smp_ready_o,
  input  logic [WORD_W-1:0] smp_left_i,
  input  logic [WORD_W-1:0] smp_right_i,
  output logic              sdata_o
);

  logic              bit_fall, lr_held, take, hold_full;
  logic [WORD_W-1:0] hold_left, hold_right;
  sdtx_fmt_e         fmt;

  assign fmt = sdtx_fmt_e'(fmt_i);

  sdtx_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_i     (bclk_i),
    .lrclk_i    (lrclk_i),
    .bit_fall_o (bit_fall),
    .lr_held_o  (lr_held)
  );

  sdtx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (smp_valid_i),
    .ready_o (smp_ready_o),
    .left_i  (smp_left_i),
    .right_i (smp_right_i),
    .take_i  (take),
    .full_o  (hold_full),
    .left_o  (hold_left),
    .right_o (hold_right)
  );

  sdtx_shift #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_fall_i   (bit_fall),
    .lrclk_i      (lrclk_i),
    .lr_held_i    (lr_held),
    .fmt_i        (fmt),
    .mute_i       (mute_i),
    .hold_full_i  (hold_full),
    .hold_left_i  (hold_left),
    .hold_right_i (hold_right),
    .take_o       (take),
    .sdata_o      (sdata_o)
  );

  AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_fall |=> $stable(sdata_o)); // R10

endmodule

// File: tb/serial_audio_tx_bench.sv
module serial_audio_tx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b1;
  logic        lrclk = 1'b0;
  logic        fmt = 1'b0;
  logic        mute = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_left = '0;
  logic [15:0] smp_right = '0;
  logic        sdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  serial_audio_tx u_serial_audio_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_i      (bclk),
    .lrclk_i     (lrclk),
    .fmt_i       (fmt),
    .mute_i      (mute),
    .smp_valid_i (smp_valid),
    .smp_ready_o (smp_ready),
    .smp_left_i  (smp_left),
    .smp_right_i (smp_right),
    .sdata_o     (sdata)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected bit for slot k of a half-frame
  function automatic logic exp_bit(input logic f, input int k, input logic [15:0] w,
                                   input logic z, input logic m);
    int i = k - (f ? 1 : 0);
    if (z || m || i < 0 || i > 15) return 1'b0;
    return w[15 - i];
  endfunction

  function automatic string bit_tag(input logic f, input int k, input logic z, input logic m);
    int i = k - (f ? 1 : 0);
    if (m) return "R9";
    if (z) return "R8";
    if (f && k == 0) return "R3";
    if (i > 15) return "R5";
    return f ? "R3" : "R2";
  endfunction

  // One half-frame: returns number of mismatching bits
  task automatic half(input logic left, input int nslots, input logic [15:0] w,
                      input logic z, output int bad);
    logic a, e;
    bad = 0;
    for (int k = 0; k < nslots; k++) begin
      @(negedge clk);
      bclk = 1'b0;
      if (k == 0) lrclk = left ^ fmt;
      repeat (3) @(negedge clk);
      a = sdata;
      e = exp_bit(fmt, k, w, z, mute);
      if (a !== e) bad++;
      check(bit_tag(fmt, k, z, mute), a, e, $sformatf("slot %0d left=%0b", k, left));
      @(negedge clk);
      bclk = 1'b1;
      repeat (3) @(negedge clk);
      check("R10", sdata, a, $sformatf("held bit slot %0d", k));
    end
  endtask

  task automatic frame(input int bpf, input logic [15:0] l, input logic [15:0] r, input logic z);
    int bl, br;
    half(1'b1, bpf / 2, l, z, bl);
    half(1'b0, bpf / 2, r, z, br);
    check_int("R4", bl + br, 0, $sformatf("channel words fmt=%0b", fmt));
    check_int("R6", bl + br, 0, $sformatf("frame of %0d clocks fmt=%0b", bpf, fmt));
  endtask

  // Park in the right half of the new format so the next left start is seen
  task automatic settle(input logic f);
    fmt = f;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      bclk = 1'b0;
      lrclk = f;
      repeat (3) @(negedge clk);
      bclk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic push(input logic [15:0] l, input logic [15:0] r);
    while (!smp_ready) @(negedge clk);
    smp_valid = 1'b1;
    smp_left  = l;
    smp_right = r;
    @(negedge clk);
    smp_valid = 1'b0;
    check("R7", smp_ready, 1'b0, "ready after accept");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL R10 watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int bpf;
    logic f;
    logic [15:0] l, r;
    void'($urandom(32'd1701));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", sdata, 1'b0, "data after reset");
    check("R1", smp_ready, 1'b1, "ready after reset");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); bclk = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", sdata, 1'b0, "idle before frame edge");
      bclk = 1'b1;
      repeat (4) @(negedge clk);
    end

    // Directed: left-justified 64, 48, 32
    push(16'h8001, 16'h7FFE); frame(64, 16'h8001, 16'h7FFE, 1'b0);
    push(16'hA5C3, 16'h0F0F); frame(48, 16'hA5C3, 16'h0F0F, 1'b0);
    push(16'hFFFF, 16'h0001); frame(32, 16'hFFFF, 16'h0001, 1'b0);
    // Directed: I2S 64 and 48
    settle(1'b1);
    push(16'h8000, 16'h0001); frame(64, 16'h8000, 16'h0001, 1'b0);
    push(16'h1234, 16'hFEDC); frame(48, 16'h1234, 16'hFEDC, 1'b0);
    // Underrun: no pair held
    frame(64, 16'h0000, 16'h0000, 1'b1);
    // Offer while full: held pair must survive
    push(16'hC001, 16'h3FFC);
    smp_valid = 1'b1; smp_left = 16'h5555; smp_right = 16'hAAAA;
    repeat (4) @(negedge clk);
    check("R7", smp_ready, 1'b0, "ready while full");
    smp_valid = 1'b0;
    frame(64, 16'hC001, 16'h3FFC, 1'b0);
    // Mute
    mute = 1'b1;
    push(16'hFFFF, 16'hFFFF); frame(48, 16'hFFFF, 16'hFFFF, 1'b0);
    mute = 1'b0;

    // Constrained random
    for (int n = 0; n < 24; n++) begin
      f = 1'($urandom_range(0, 1));
      if (f != fmt) settle(f);
      if (f) bpf = ($urandom_range(0, 1) == 0) ? 64 : 48;
      else begin
        case ($urandom_range(0, 2))
          0: bpf = 64;
          1: bpf = 48;
          default: bpf = 32;
        endcase
      end
      l = 16'($urandom);
      r = 16'($urandom);
      mute = ($urandom_range(0, 5) == 0);
      push(l, r);
      frame(bpf, l, r, 1'b0);
      mute = 1'b0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule